// File: doc/BRIEF.md
# Dual-Clock FIFO with Symmetric Edge-Proximity Flag

This block is a 1024-word by 9-bit first-in first-out buffer. Its write side and read side run on unrelated clocks. Words enter on the write clock and leave, oldest first, on the read clock. The read word sits in a register and stays on the output until the next successful read.

Four status outputs describe the fill level:
- an active-low empty flag,
- an active-low full flag,
- an active-high half-full flag,
- a single active-high proximity flag, which is high when the fill level is close to either end of its range.

The proximity window uses one offset X for both ends. X is taken from the low nine data-input bits when the threshold-set input falls. It becomes active only during a reset:
- If the threshold-set input is held high through the reset, X becomes 256.
- If it is held low, the value last captured is used.

Full, half-full and the proximity flag are decoded in the write domain. Empty is decoded in the read domain. Each side sees the other side's pointer through a Gray-coded two-stage synchronizer, so each flag can trail the true level by a few cycles of its own clock.

Top module: `twin_clock_fifo`

## Requirements
- R1: While `rst` is high, and after it falls, before any write: `empty_n` is 0, `full_n` is 1, `half_full` is 0, `near_edge` is 1 and `rd_data` is 0.
- R2: Words come out on `rd_data` in the order they were written. `rd_data` changes on the `rd_clk` rising edge where `rd_en` is high and the FIFO is not empty.
- R3: Once the pointers have settled, `empty_n` is 0 exactly when the FIFO holds no words.
- R4: Once settled, `full_n` is 0 exactly when the FIFO holds 1024 words. A write attempted while full stores nothing, and the level never exceeds 1024.
- R5: A read attempted while empty changes nothing. `rd_data` keeps the last word read.
- R6: Once settled, `half_full` is 1 when the level is 512 or more and 0 when it is 511 or less.
- R7: Once settled, `near_edge` is 1 when the level L satisfies L <= X or L >= 1024 - X, and 0 when X < L < 1024 - X.
- R8: A high-to-low change of `thr_set`, sampled on `wr_clk`, captures `wr_data[8:0]` as the pending offset (0 to 511). A reset taken with `thr_set` low makes the pending offset the active X.
- R9: A reset taken with `thr_set` high sets X to 256.
- R10: A later reset with `thr_set` still low and no new capture keeps the previously captured X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high synchronous reset, seen by both clocks |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | 9 | Write word; also the offset source on a `thr_set` fall |
| thr_set | input | 1 | Offset capture strobe; its level during reset picks default or captured X |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | 9 | Registered read word |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| half_full | output | 1 | High at 512 or more words |
| near_edge | output | 1 | High within X words of either end |

## Verification
The assertions take the following for granted about the inputs:
- `rst` stays high for several cycles of both clocks.
- `thr_set` does not fall in the same write cycle as a reset edge.
- `thr_set` holds one steady level for the whole reset.
- The pending offset has been captured at least once before any reset taken with `thr_set` low.

The stimulus respects this. It changes `thr_set` only outside reset, or one cycle before it. It issues no requests while reset is high.

After every single write or read, the stimulus waits several cycles of both clocks so the synchronizers settle before the flags are compared. This lets the bench compare every fill level from 0 to 1024 against an arithmetic model, for offsets of 0, 100, 256 and 511.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int unsigned TCF_AW      = 10;
    localparam int unsigned TCF_DW      = 9;
    localparam int unsigned TCF_DEF_THR = 256;
    localparam int unsigned TCF_SYNC    = 2;

    typedef struct packed {
        logic full_n;
        logic half_full;
        logic near_edge;
    } wr_status_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tcf_sync.sv
module tcf_sync #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tcf_wr_ctl.sv
module tcf_wr_ctl
    import tcf_pkg::*;
#(
    parameter int unsigned AW      = TCF_AW,
    parameter int unsigned TW      = TCF_AW - 1,
    parameter int unsigned DEF_THR = TCF_DEF_THR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          thr_strobe,
    input  logic [TW-1:0] thr_data,
    input  logic [AW:0]   rd_gray_s,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_gray,
    output wr_status_t    status
);

    localparam int unsigned   PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH   = PW'(1) << AW;
    localparam logic [PW-1:0] HALF    = PW'(1) << (AW - 1);
    localparam logic [TW-1:0] THR_RST = TW'(DEF_THR);

    logic [PW-1:0] wr_bin, rd_bin_s, level, lo_lim, hi_lim;
    logic [TW-1:0] thr_pend, thr_live;
    logic          strobe_q, full;

    // level as seen from the write side; may read high, never low
    assign rd_bin_s = PW'(gray_to_bin(32'(rd_gray_s)));
    assign level    = wr_bin - rd_bin_s;
    assign full     = (level == DEPTH);
    assign wr_fire  = wr_en & ~full;
    assign wr_addr  = wr_bin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_fire) begin
            wr_bin  <= wr_bin + 1'b1;
            wr_gray <= PW'(bin_to_gray(32'(wr_bin + 1'b1)));
        end
    end

    // pending offset: captured on a falling strobe, survives reset
    always_ff @(posedge clk) begin
        strobe_q <= thr_strobe;
        if (strobe_q && !thr_strobe) begin
            thr_pend <= thr_data;
        end
    end

    // live offset: committed only while reset is applied
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_live <= thr_strobe ? THR_RST : thr_pend;
        end
    end

    assign lo_lim = PW'(thr_live);
    assign hi_lim = DEPTH - PW'(thr_live);

    always_comb begin
        status.full_n    = ~full;
        status.half_full = (level >= HALF);
        status.near_edge = (level <= lo_lim) || (level >= hi_lim);
    end

    // R4
    wr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(wr_gray));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH);

    // R7
    ends_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((level == '0) || full) |-> status.near_edge);

endmodule

// File: rtl/tcf_rd_ctl.sv
module tcf_rd_ctl
    import tcf_pkg::*;
#(
    parameter int unsigned AW = TCF_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wr_gray_s,
    output logic          rd_fire,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_gray,
    output logic          empty_n
);

    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] rd_bin, wr_bin_s;
    logic          empty;

    assign wr_bin_s = PW'(gray_to_bin(32'(wr_gray_s)));
    assign empty    = (rd_bin == wr_bin_s);
    assign rd_fire  = rd_en & ~empty;
    assign rd_addr  = rd_bin[AW-1:0];
    assign empty_n  = ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_fire) begin
            rd_bin  <= rd_bin + 1'b1;
            rd_gray <= PW'(bin_to_gray(32'(rd_bin + 1'b1)));
        end
    end

    // R5
    rd_block_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rd_gray));

endmodule

// File: rtl/tcf_store.sv
module tcf_store
    import tcf_pkg::*;
#(
    parameter int unsigned AW = TCF_AW,
    parameter int unsigned DW = TCF_DW
) (
    input  logic          wr_clk,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          rd_fire,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_fire) begin
            cells[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_fire) begin
            rd_data <= cells[rd_addr];
        end
    end

    // R5
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        !rd_fire |=> $stable(rd_data));

endmodule

// File: rtl/twin_clock_fifo.sv
module twin_clock_fifo
    import tcf_pkg::*;
#(
    parameter int unsigned AW          = TCF_AW,
    parameter int unsigned DW          = TCF_DW,
    parameter int unsigned DEF_THR     = TCF_DEF_THR,
    parameter int unsigned SYNC_STAGES = TCF_SYNC
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          thr_set,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_full,
    output logic          near_edge
);

    localparam int unsigned PW = AW + 1;
    localparam int unsigned TW = AW - 1;

    logic          wr_fire, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    wr_status_t    wstat;

    tcf_wr_ctl #(.AW(AW), .TW(TW), .DEF_THR(DEF_THR)) u_wr (
        .clk        (wr_clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .thr_strobe (thr_set),
        .thr_data   (wr_data[TW-1:0]),
        .rd_gray_s  (rd_gray_s),
        .wr_fire    (wr_fire),
        .wr_addr    (wr_addr),
        .wr_gray    (wr_gray),
        .status     (wstat)
    );

    tcf_rd_ctl #(.AW(AW)) u_rd (
        .clk       (rd_clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .wr_gray_s (wr_gray_s),
        .rd_fire   (rd_fire),
        .rd_addr   (rd_addr),
        .rd_gray   (rd_gray),
        .empty_n   (empty_n)
    );

    tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk (rd_clk),
        .rst (rst),
        .d   (wr_gray),
        .q   (wr_gray_s)
    );

    tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk (wr_clk),
        .rst (rst),
        .d   (rd_gray),
        .q   (rd_gray_s)
    );

    tcf_store #(.AW(AW), .DW(DW)) u_store (
        .wr_clk  (wr_clk),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rst     (rst),
        .rd_fire (rd_fire),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign full_n    = wstat.full_n;
    assign half_full = wstat.half_full;
    assign near_edge = wstat.near_edge;

endmodule

// File: tb/twin_clock_fifo_test.sv
module twin_clock_fifo_test;

    localparam int DEPTH = 1024;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       thr_set = 1'b1;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       empty_n, full_n, half_full, near_edge;

    int n_chk = 0;
    int n_fail = 0;
    int lvl = 0;
    int x_cur = 256;

    always #10 wr_clk = ~wr_clk;
    always #13 rd_clk = ~rd_clk;

    twin_clock_fifo uut (
        .wr_clk    (wr_clk),
        .rd_clk    (rd_clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .thr_set   (thr_set),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .empty_n   (empty_n),
        .full_n    (full_n),
        .half_full (half_full),
        .near_edge (near_edge)
    );

    function automatic int pat(input int i, input int salt);
        return (i * 7 + salt) % 512;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (level %0d, X %0d): actual=%0d expected=%0d",
                     what, lvl, x_cur, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk("R3 empty_n", int'(empty_n), int'(lvl != 0));
        chk("R4 full_n", int'(full_n), int'(lvl != DEPTH));
        chk("R6 half_full", int'(half_full), int'(lvl >= 512));
        chk({"R7 near_edge ", tag}, int'(near_edge),
            int'((lvl <= x_cur) || (lvl >= DEPTH - x_cur)));
    endtask

    task automatic settle();
        repeat (3) @(negedge wr_clk);
        repeat (3) @(negedge rd_clk);
        #1;
    endtask

    task automatic push(input int v);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = 9'(v);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic do_reset(input logic lvl_set);
        @(negedge wr_clk);
        rst = 1'b1;
        thr_set = lvl_set;
        repeat (6) @(negedge wr_clk);
        rst = 1'b0;
        repeat (4) @(negedge wr_clk);
        #1;
        lvl = 0;
    endtask

    task automatic check_reset_state();
        chk("R1 empty_n", int'(empty_n), 0);
        chk("R1 full_n", int'(full_n), 1);
        chk("R1 half_full", int'(half_full), 0);
        chk("R1 near_edge", int'(near_edge), 1);
        chk("R1 rd_data", int'(rd_data), 0);
    endtask

    // R8: a falling thr_set captures wr_data[8:0]
    task automatic define_x(input int v);
        @(negedge wr_clk);
        thr_set = 1'b1;
        wr_data = 9'(v);
        @(negedge wr_clk);
        @(negedge wr_clk);
        thr_set = 1'b0;
        @(negedge wr_clk);
        @(negedge wr_clk);
    endtask

    // fill to 'limit' words one at a time, then drain, checking flags at every level
    task automatic sweep(input string tag, input int salt, input int limit);
        for (int i = 0; i < limit; i++) begin
            push(pat(i, salt));
            lvl++;
            settle();
            chk_flags(tag);
        end
        if (limit == DEPTH) begin
            push(9'h1FF);        // R4: rejected while full
            settle();
            chk_flags(tag);
        end
        for (int k = 0; k < limit; k++) begin
            pop();
            chk("R2 order", int'(rd_data), pat(k, salt));
            lvl--;
            settle();
            chk_flags(tag);
        end
        pop();                   // R5: read while empty
        chk("R5 hold", int'(rd_data), pat(limit - 1, salt));
        settle();
        chk_flags(tag);
    endtask

    initial begin
        #(190000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 / R9: reset with thr_set high selects X = 256
        do_reset(1'b1);
        check_reset_state();
        x_cur = 256;
        sweep("R9", 3, DEPTH);

        // R8: X = 0
        define_x(0);
        do_reset(1'b0);
        x_cur = 0;
        sweep("R8", 11, DEPTH);

        // R8: X = 100
        define_x(100);
        do_reset(1'b0);
        x_cur = 100;
        sweep("R8", 29, DEPTH);

        // R10: leave some data, reset again with thr_set low and no capture
        for (int i = 0; i < 5; i++) push(pat(i, 5));
        settle();
        do_reset(1'b0);
        check_reset_state();
        x_cur = 100;
        sweep("R10", 41, 120);

        // R8: X = 511, only level 512 is outside the window
        define_x(511);
        do_reset(1'b0);
        x_cur = 511;
        sweep("R8", 57, DEPTH);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule